// File: doc/BRIEF.md
# Capability Seal and Unseal Checker

This block decides whether a seal or unseal operation on two capabilities may proceed. A source capability and a type capability arrive together with an operation select and three register numbers: destination, source and type. The two capabilities are a tag, a sealed flag, base, length, offset, a 24-bit object type and a seal-permission bit. The block also takes an accessibility flag for each of the three register numbers. The type cursor is the type capability's base plus its offset.

The checks run as one fixed-priority chain, and only the first failure in the chain is reported. A request produces one of two outcomes. On success the block gives a result capability with a write enable. On failure it gives a single exception with a cause code and the number of the register it blames. The result is registered, so the outcome appears one clock after the request is sampled. The register file, memory and exception vectoring belong to the surrounding core.

Top module: `cap_seal_checker`

## Requirements
- R1: The outcome of a request sampled at a rising edge with `req_valid` high appears on the outputs after that edge. A cycle without a request leaves both `wr_en` and `exc_valid` low after the next edge.
- R2: If any register is inaccessible, the block raises cause 1 (access). It blames the first inaccessible register in the order destination, source, type. This check takes priority over every other check.
- R3: An untagged source raises cause 2 (tag) against the source register. If the source is tagged but the type capability is untagged, cause 2 is raised against the type register.
- R4: For a seal, a sealed source raises cause 3 (seal) against the source register. For either operation, a sealed type capability raises cause 3 against the type register. The source seal check comes before the type seal check.
- R5: A type capability without seal permission raises cause 5 (permission) against the type register.
- R6: For either operation, a type offset greater than or equal to the type length raises cause 6 (length) against the type register. The comparison is unsigned.
- R7: For a seal, a type cursor above 2^24-1 raises cause 6 against the type register. The cursor is computed 65 bits wide, so a base plus offset that passes 2^64 does not wrap.
- R8: A successful seal writes the source capability with the sealed flag set and the object type set to the low 24 bits of the type cursor. Every other field is copied from the source.
- R9: For an unseal, an unsealed source raises cause 3 against the source register. A type cursor that differs from the source object type raises cause 4 (type) against the type register. The type check comes before the permission and length checks.
- R10: A successful unseal writes the source capability with the sealed flag cleared and the object type set to zero.
- R11: Every request produces exactly one of `wr_en` or `exc_valid`. When an exception is raised, `wr_en` stays low.
- R12: While `rst_n` is low, `wr_en` and `exc_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| op_unseal | input | 1 | 0 selects seal, 1 selects unseal |
| dst_idx | input | 5 | Destination register number |
| src_idx | input | 5 | Source register number |
| typ_idx | input | 5 | Type register number |
| dst_ok | input | 1 | Destination register is accessible |
| src_ok | input | 1 | Source register is accessible |
| typ_ok | input | 1 | Type register is accessible |
| src_tag | input | 1 | Source tag |
| src_sealed | input | 1 | Source sealed flag |
| src_perm_seal | input | 1 | Source seal permission |
| src_base | input | 64 | Source base |
| src_length | input | 64 | Source length |
| src_offset | input | 64 | Source offset |
| src_otype | input | 24 | Source object type |
| typ_tag | input | 1 | Type capability tag |
| typ_sealed | input | 1 | Type capability sealed flag |
| typ_perm_seal | input | 1 | Type capability seal permission |
| typ_base | input | 64 | Type capability base |
| typ_length | input | 64 | Type capability length |
| typ_offset | input | 64 | Type capability offset |
| wr_en | output | 1 | Result capability is valid for write-back |
| wr_tag | output | 1 | Result tag |
| wr_sealed | output | 1 | Result sealed flag |
| wr_perm_seal | output | 1 | Result seal permission |
| wr_base | output | 64 | Result base |
| wr_length | output | 64 | Result length |
| wr_offset | output | 64 | Result offset |
| wr_otype | output | 24 | Result object type |
| exc_valid | output | 1 | An exception is reported |
| exc_cause | output | 3 | Cause code: 1 access, 2 tag, 3 seal, 4 type, 5 permission, 6 length |
| exc_reg | output | 5 | Number of the blamed register |

## Verification
The assertions check, on every cycle, properties that hold for any input. Each request resolves to exactly one outcome, and an idle cycle produces neither. An inaccessible destination always wins with an access fault that blames that register. An untagged source never yields a write. A seal result is always sealed, and an unseal result is always unsealed with a zero object type.

Other behaviour depends on specific stimulus and is shown only by the bench scenarios. These include the relative order of neighbouring checks, such as the type-match failure winning over a missing permission. They also include the exact boundaries: offset equal to length, cursor at and just above 2^24-1, and a base plus offset that wraps. Finally, the bench compares the copied result fields against an independent model over random capabilities.

// File: rtl/cap_seal_pkg.sv
package cap_seal_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_ACCESS = 3'd1,
    CAUSE_TAG    = 3'd2,
    CAUSE_SEAL   = 3'd3,
    CAUSE_TYPE   = 3'd4,
    CAUSE_PERM   = 3'd5,
    CAUSE_LENGTH = 3'd6
  } cause_e;

  typedef enum logic [1:0] {
    BLAME_DST = 2'd0,
    BLAME_SRC = 2'd1,
    BLAME_TYP = 2'd2
  } blame_e;

endpackage

// File: rtl/cap_seal_bounds.sv
// Type-cursor arithmetic and the unsigned bounds and type-match comparisons.
module cap_seal_bounds #(
  parameter int ADDR_W  = 64,
  parameter int OTYPE_W = 24
) (
  input  logic [ADDR_W-1:0]  typ_base,
  input  logic [ADDR_W-1:0]  typ_offset,
  input  logic [ADDR_W-1:0]  typ_length,
  input  logic [OTYPE_W-1:0] src_otype,
  output logic [OTYPE_W-1:0] cursor_lo,
  output logic               off_ge_len,
  output logic               cursor_over_max,
  output logic               cursor_ne_otype
);
  localparam int CUR_W = ADDR_W + 1;
  localparam logic [CUR_W-1:0] MAX_OTYPE = {{(CUR_W-OTYPE_W){1'b0}}, {OTYPE_W{1'b1}}};

  logic [CUR_W-1:0] cursor;
  logic [CUR_W-1:0] otype_ext;

  always_comb begin
    cursor          = {1'b0, typ_base} + {1'b0, typ_offset};
    otype_ext       = {{(CUR_W-OTYPE_W){1'b0}}, src_otype};
    cursor_lo       = cursor[OTYPE_W-1:0];
    off_ge_len      = (typ_offset >= typ_length);
    cursor_over_max = (cursor > MAX_OTYPE);
    cursor_ne_otype = (cursor != otype_ext);
  end
endmodule

// File: rtl/cap_seal_prio.sv
// Fixed-priority fault chain; the first failing condition sets cause and blame.
module cap_seal_prio
  import cap_seal_pkg::*;
(
  input  logic   op_unseal,
  input  logic   dst_ok,
  input  logic   src_ok,
  input  logic   typ_ok,
  input  logic   src_tag,
  input  logic   typ_tag,
  input  logic   src_sealed,
  input  logic   typ_sealed,
  input  logic   typ_perm_seal,
  input  logic   off_ge_len,
  input  logic   cursor_over_max,
  input  logic   cursor_ne_otype,
  output logic   fault,
  output cause_e cause,
  output blame_e blame
);
  always_comb begin
    fault = 1'b1;
    cause = CAUSE_NONE;
    blame = BLAME_TYP;
    if (!dst_ok) begin
      cause = CAUSE_ACCESS; blame = BLAME_DST;
    end else if (!src_ok) begin
      cause = CAUSE_ACCESS; blame = BLAME_SRC;
    end else if (!typ_ok) begin
      cause = CAUSE_ACCESS; blame = BLAME_TYP;
    end else if (!src_tag) begin
      cause = CAUSE_TAG; blame = BLAME_SRC;
    end else if (!typ_tag) begin
      cause = CAUSE_TAG; blame = BLAME_TYP;
    end else if (src_sealed == op_unseal ? 1'b0 : 1'b1) begin
      // seal needs an unsealed source, unseal needs a sealed one
      cause = CAUSE_SEAL; blame = BLAME_SRC;
    end else if (typ_sealed) begin
      cause = CAUSE_SEAL; blame = BLAME_TYP;
    end else if (op_unseal && cursor_ne_otype) begin
      cause = CAUSE_TYPE; blame = BLAME_TYP;
    end else if (!typ_perm_seal) begin
      cause = CAUSE_PERM; blame = BLAME_TYP;
    end else if (off_ge_len) begin
      cause = CAUSE_LENGTH; blame = BLAME_TYP;
    end else if (!op_unseal && cursor_over_max) begin
      cause = CAUSE_LENGTH; blame = BLAME_TYP;
    end else begin
      fault = 1'b0;
    end
  end
endmodule

// File: rtl/cap_seal_result.sv
// Result capability: copy of the source with sealed flag and object type replaced.
module cap_seal_result #(
  parameter int OTYPE_W = 24
) (
  input  logic               op_unseal,
  input  logic [OTYPE_W-1:0] cursor_lo,
  output logic               res_sealed,
  output logic [OTYPE_W-1:0] res_otype
);
  always_comb begin
    res_sealed = !op_unseal;
    res_otype  = op_unseal ? '0 : cursor_lo;
  end
endmodule

// File: rtl/cap_seal_checker.sv
module cap_seal_checker
  import cap_seal_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int OTYPE_W = 24,
  parameter int REG_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               op_unseal,
  input  logic [REG_W-1:0]   dst_idx,
  input  logic [REG_W-1:0]   src_idx,
  input  logic [REG_W-1:0]   typ_idx,
  input  logic               dst_ok,
  input  logic               src_ok,
  input  logic               typ_ok,
  input  logic               src_tag,
  input  logic               src_sealed,
  input  logic               src_perm_seal,
  input  logic [ADDR_W-1:0]  src_base,
  input  logic [ADDR_W-1:0]  src_length,
  input  logic [ADDR_W-1:0]  src_offset,
  input  logic [OTYPE_W-1:0] src_otype,
  input  logic               typ_tag,
  input  logic               typ_sealed,
  input  logic               typ_perm_seal,
  input  logic [ADDR_W-1:0]  typ_base,
  input  logic [ADDR_W-1:0]  typ_length,
  input  logic [ADDR_W-1:0]  typ_offset,
  output logic               wr_en,
  output logic               wr_tag,
  output logic               wr_sealed,
  output logic               wr_perm_seal,
  output logic [ADDR_W-1:0]  wr_base,
  output logic [ADDR_W-1:0]  wr_length,
  output logic [ADDR_W-1:0]  wr_offset,
  output logic [OTYPE_W-1:0] wr_otype,
  output logic               exc_valid,
  output logic [2:0]         exc_cause,
  output logic [REG_W-1:0]   exc_reg
);
  logic [OTYPE_W-1:0] cursor_lo;
  logic               off_ge_len, cursor_over_max, cursor_ne_otype;
  logic               fault;
  cause_e             cause;
  blame_e             blame;
  logic               res_sealed;
  logic [OTYPE_W-1:0] res_otype;

  cap_seal_bounds #(.ADDR_W(ADDR_W), .OTYPE_W(OTYPE_W)) u_bounds (
    .typ_base        (typ_base),
    .typ_offset      (typ_offset),
    .typ_length      (typ_length),
    .src_otype       (src_otype),
    .cursor_lo       (cursor_lo),
    .off_ge_len      (off_ge_len),
    .cursor_over_max (cursor_over_max),
    .cursor_ne_otype (cursor_ne_otype)
  );

  cap_seal_prio u_prio (
    .op_unseal       (op_unseal),
    .dst_ok          (dst_ok),
    .src_ok          (src_ok),
    .typ_ok          (typ_ok),
    .src_tag         (src_tag),
    .typ_tag         (typ_tag),
    .src_sealed      (src_sealed),
    .typ_sealed      (typ_sealed),
    .typ_perm_seal   (typ_perm_seal),
    .off_ge_len      (off_ge_len),
    .cursor_over_max (cursor_over_max),
    .cursor_ne_otype (cursor_ne_otype),
    .fault           (fault),
    .cause           (cause),
    .blame           (blame)
  );

  cap_seal_result #(.OTYPE_W(OTYPE_W)) u_result (
    .op_unseal  (op_unseal),
    .cursor_lo  (cursor_lo),
    .res_sealed (res_sealed),
    .res_otype  (res_otype)
  );

  // next-state
  logic             nxt_wr_en, nxt_exc_valid, load_en;
  logic [REG_W-1:0] nxt_exc_reg;

  always_comb begin
    load_en       = req_valid;
    nxt_wr_en     = req_valid & ~fault;
    nxt_exc_valid = req_valid & fault;
    unique case (blame)
      BLAME_DST: nxt_exc_reg = dst_idx;
      BLAME_SRC: nxt_exc_reg = src_idx;
      default:   nxt_exc_reg = typ_idx;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en        <= 1'b0;
      exc_valid    <= 1'b0;
      wr_tag       <= 1'b0;
      wr_sealed    <= 1'b0;
      wr_perm_seal <= 1'b0;
      wr_base      <= '0;
      wr_length    <= '0;
      wr_offset    <= '0;
      wr_otype     <= '0;
      exc_cause    <= '0;
      exc_reg      <= '0;
    end else begin
      wr_en     <= nxt_wr_en;
      exc_valid <= nxt_exc_valid;
      if (load_en) begin
        wr_tag       <= src_tag;
        wr_sealed    <= res_sealed;
        wr_perm_seal <= src_perm_seal;
        wr_base      <= src_base;
        wr_length    <= src_length;
        wr_offset    <= src_offset;
        wr_otype     <= res_otype;
        exc_cause    <= cause;
        exc_reg      <= nxt_exc_reg;
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!wr_en && !exc_valid));

  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (wr_en != exc_valid));

  // R2
  dst_access_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dst_ok) |=> (exc_valid && exc_cause == 3'd1 && exc_reg == $past(dst_idx)));

  // R3
  untagged_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !src_tag) |=> !wr_en);

  // R8
  seal_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !op_unseal) |=> (!wr_en || wr_sealed));

  // R10
  unseal_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_unseal) |=> (!wr_en || (!wr_sealed && wr_otype == '0)));

endmodule

// File: tb/cap_seal_checker_tb.sv
`timescale 1ns/1ps
module cap_seal_checker_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic        req_valid, op_unseal;
  logic [4:0]  dst_idx, src_idx, typ_idx;
  logic        dst_ok, src_ok, typ_ok;
  logic        src_tag, src_sealed, src_perm_seal;
  logic [63:0] src_base, src_length, src_offset;
  logic [23:0] src_otype;
  logic        typ_tag, typ_sealed, typ_perm_seal;
  logic [63:0] typ_base, typ_length, typ_offset;
  logic        wr_en, wr_tag, wr_sealed, wr_perm_seal;
  logic [63:0] wr_base, wr_length, wr_offset;
  logic [23:0] wr_otype;
  logic        exc_valid;
  logic [2:0]  exc_cause;
  logic [4:0]  exc_reg;

  cap_seal_checker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_unseal(op_unseal),
    .dst_idx(dst_idx), .src_idx(src_idx), .typ_idx(typ_idx),
    .dst_ok(dst_ok), .src_ok(src_ok), .typ_ok(typ_ok),
    .src_tag(src_tag), .src_sealed(src_sealed), .src_perm_seal(src_perm_seal),
    .src_base(src_base), .src_length(src_length), .src_offset(src_offset),
    .src_otype(src_otype),
    .typ_tag(typ_tag), .typ_sealed(typ_sealed), .typ_perm_seal(typ_perm_seal),
    .typ_base(typ_base), .typ_length(typ_length), .typ_offset(typ_offset),
    .wr_en(wr_en), .wr_tag(wr_tag), .wr_sealed(wr_sealed), .wr_perm_seal(wr_perm_seal),
    .wr_base(wr_base), .wr_length(wr_length), .wr_offset(wr_offset), .wr_otype(wr_otype),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_reg(exc_reg)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expected values
  logic        e_exc;
  logic [2:0]  e_cause;
  logic [4:0]  e_reg;
  logic [23:0] e_otype;
  string       e_req;

  task automatic model();
    logic [64:0] cur;
    cur   = {1'b0, typ_base} + {1'b0, typ_offset};
    e_exc = 1'b1; e_reg = typ_idx; e_otype = 24'd0;
    if (!dst_ok)      begin e_cause = 3'd1; e_reg = dst_idx; e_req = "R2"; end
    else if (!src_ok) begin e_cause = 3'd1; e_reg = src_idx; e_req = "R2"; end
    else if (!typ_ok) begin e_cause = 3'd1; e_req = "R2"; end
    else if (!src_tag) begin e_cause = 3'd2; e_reg = src_idx; e_req = "R3"; end
    else if (!typ_tag) begin e_cause = 3'd2; e_req = "R3"; end
    else if (!op_unseal && src_sealed) begin e_cause = 3'd3; e_reg = src_idx; e_req = "R4"; end
    else if (op_unseal && !src_sealed) begin e_cause = 3'd3; e_reg = src_idx; e_req = "R9"; end
    else if (typ_sealed) begin e_cause = 3'd3; e_req = "R4"; end
    else if (op_unseal && cur != {41'd0, src_otype}) begin e_cause = 3'd4; e_req = "R9"; end
    else if (!typ_perm_seal) begin e_cause = 3'd5; e_req = "R5"; end
    else if (typ_offset >= typ_length) begin e_cause = 3'd6; e_req = "R6"; end
    else if (!op_unseal && cur > 65'hFF_FFFF) begin e_cause = 3'd6; e_req = "R7"; end
    else begin
      e_exc = 1'b0; e_cause = 3'd0;
      e_otype = op_unseal ? 24'd0 : cur[23:0];
      e_req = op_unseal ? "R10" : "R8";
    end
  endtask

  // Inputs are set at a falling edge; result is sampled at the next falling edge.
  task automatic run_case();
    bit ok;
    model();
    req_valid = 1'b1;
    @(negedge clk);
    checks++;
    ok = (wr_en == !e_exc) && (exc_valid == e_exc);
    if (ok && e_exc) ok = (exc_cause == e_cause) && (exc_reg == e_reg);
    if (ok && !e_exc)
      ok = (wr_sealed == !op_unseal) && (wr_otype == e_otype) && (wr_tag == src_tag) &&
           (wr_perm_seal == src_perm_seal) && (wr_base == src_base) &&
           (wr_length == src_length) && (wr_offset == src_offset);
    if (!ok) begin
      fails++;
      $display("FAIL %s (R11): got wr_en=%0b exc=%0b cause=%0d reg=%0d otype=%h sealed=%0b, exp exc=%0b cause=%0d reg=%0d otype=%h",
               e_req, wr_en, exc_valid, exc_cause, exc_reg, wr_otype, wr_sealed,
               e_exc, e_cause, e_reg, e_otype);
    end
    req_valid = 1'b0;
  endtask

  task automatic legal_seal();
    op_unseal = 0; dst_idx = 5'd3; src_idx = 5'd7; typ_idx = 5'd12;
    dst_ok = 1; src_ok = 1; typ_ok = 1;
    src_tag = 1; src_sealed = 0; src_perm_seal = 0;
    src_base = 64'h4000; src_length = 64'h800; src_offset = 64'h10; src_otype = 24'h0;
    typ_tag = 1; typ_sealed = 0; typ_perm_seal = 1;
    typ_base = 64'h100; typ_length = 64'h1000; typ_offset = 64'h20;
  endtask

  task automatic legal_unseal();
    legal_seal();
    op_unseal = 1; src_sealed = 1; src_otype = 24'h120;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    legal_seal();
    req_valid = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset holds outputs low even with a request present
    checks++;
    if (wr_en || exc_valid) begin
      fails++; $display("FAIL R12: got wr_en=%0b exc=%0b, expected 0 0", wr_en, exc_valid);
    end
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R8 success; R1 next idle cycle is quiet
    legal_seal(); run_case();
    @(negedge clk);
    checks++;
    if (wr_en || exc_valid) begin
      fails++; $display("FAIL R1: got wr_en=%0b exc=%0b, expected 0 0", wr_en, exc_valid);
    end
    // R2 ordering of access faults
    legal_seal(); dst_ok = 0; src_ok = 0; run_case();
    legal_seal(); src_ok = 0; typ_ok = 0; run_case();
    legal_seal(); typ_ok = 0; src_tag = 0; run_case();
    // R3 tag order
    legal_seal(); src_tag = 0; typ_tag = 0; run_case();
    legal_seal(); typ_tag = 0; run_case();
    // R4 seal order
    legal_seal(); src_sealed = 1; typ_sealed = 1; run_case();
    legal_seal(); typ_sealed = 1; typ_perm_seal = 0; run_case();
    // R5
    legal_seal(); typ_perm_seal = 0; typ_offset = 64'h2000; run_case();
    // R6 boundary, offset equal to and one below length
    legal_seal(); typ_offset = typ_length; run_case();
    legal_seal(); typ_offset = typ_length - 1; run_case();
    legal_unseal(); typ_base = 64'h0; typ_offset = 64'h1000; src_otype = 24'h1000; run_case();
    // R7 cursor at max passes, one above fails, wrap beyond 2^64 fails
    legal_seal(); typ_base = 64'hFF_FF00; typ_offset = 64'hFF; typ_length = 64'h1000; run_case();
    legal_seal(); typ_base = 64'hFF_FF00; typ_offset = 64'h100; typ_length = 64'h1000; run_case();
    legal_seal(); typ_base = 64'hFFFF_FFFF_FFFF_FFFF; typ_offset = 64'h2; typ_length = 64'h10; run_case();
    // R9 unseal ordering
    legal_unseal(); src_sealed = 0; run_case();
    legal_unseal(); src_otype = 24'h121; typ_perm_seal = 0; run_case();
    legal_unseal(); typ_perm_seal = 0; run_case();
    // R10 success
    legal_unseal(); src_perm_seal = 1; run_case();

    // random mix
    for (int i = 0; i < 600; i++) begin
      op_unseal = $urandom_range(0, 1);
      dst_idx = 5'($urandom); src_idx = 5'($urandom); typ_idx = 5'($urandom);
      dst_ok = ($urandom_range(0, 15) != 0); src_ok = ($urandom_range(0, 15) != 0);
      typ_ok = ($urandom_range(0, 15) != 0);
      src_tag = ($urandom_range(0, 9) != 0); typ_tag = ($urandom_range(0, 9) != 0);
      src_sealed = op_unseal ? ($urandom_range(0, 9) != 0) : ($urandom_range(0, 9) == 0);
      typ_sealed = ($urandom_range(0, 9) == 0);
      src_perm_seal = $urandom_range(0, 1);
      typ_perm_seal = ($urandom_range(0, 9) != 0);
      src_base = {$urandom, $urandom}; src_length = {$urandom, $urandom};
      src_offset = {$urandom, $urandom};
      typ_base = 64'($urandom_range(0, 32'h00FF_FFFF));
      typ_offset = 64'($urandom_range(0, 32'h000F_FFFF));
      typ_length = 64'($urandom_range(0, 32'h0020_0000));
      if ($urandom_range(0, 7) == 0) typ_base = {$urandom, $urandom};
      src_otype = ($urandom_range(0, 3) != 0) ? 24'(typ_base + typ_offset) : 24'($urandom);
      run_case();
      if ($urandom_range(0, 5) == 0) @(negedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule